// File: doc/BRIEF.md
# Masked packed unsigned minimum unit

This block is a vector datapath stage. It takes two source vectors of up to 512 bits and returns, lane by lane, the smaller of the two values, with both values read as unsigned integers. A lane is 32 or 64 bits wide. The active vector length is 128, 256 or 512 bits. The result is registered, and a one-cycle valid travels with it.

In the extended mode, three inputs control how each lane is written. A per-lane write mask, used only when the mask enable is set, chooses which lanes get the minimum. Lanes whose mask bit is clear either keep the old destination value (merge) or are cleared to zero (zeroing). A broadcast request applies the lowest element of the second source to every lane, but only when the second source is marked as coming from memory. Every destination bit above the active length is cleared.

In the legacy mode, the old destination value is also the first operand. The unit works on 128 bits with 32-bit lanes and keeps the destination bits above 128 unchanged. The unit raises no exceptions of any kind.

Top module: `masked_umin`

## Requirements
- R1: In each active lane where the lane is written, the result is the first operand if it is strictly smaller as an unsigned number, and the second operand otherwise. A tie therefore yields the second operand.
- R2: `elem64`=0 selects 32-bit lanes and `elem64`=1 selects 64-bit lanes. Lane j occupies bits [j*size +: size].
- R3: `vlen` encodes the active length: 0 means 128 bits, 1 means 256 bits, and 2 or 3 mean 512 bits. In the extended mode (`legacy`=0), all `dst` bits at or above the active length are 0.
- R4: With `mask_en`=1 and `zero_mode`=0, an active lane j whose bit `mask[j]` is 0 takes the lane j value of `old_dst`. With `mask_en`=0, every active lane is computed whatever `mask` holds.
- R5: With `mask_en`=1 and `zero_mode`=1, an active lane j whose bit `mask[j]` is 0 is written as zero.
- R6: Mask bits at or above the active lane count have no effect on `dst`.
- R7: With `bcast`=1 and `src2_mem`=1, every lane compares against `src2` bits [size-1:0], where size is the lane width.
- R8: With `src2_mem`=0, `bcast` has no effect, and each lane uses its own `src2` lane.
- R9: With `legacy`=1:
  - the first operand is `old_dst`, and `src1` is ignored;
  - the lanes are 32 bits and the length is 128 bits;
  - `mask_en`, `mask`, `bcast`, `elem64` and `vlen` are ignored;
  - `dst` bits [DW-1:128] take the corresponding `old_dst` bits.
- R10: After reset, `dst`=0 and `out_valid`=0. `out_valid` equals `in_valid` from one cycle earlier. `dst` is loaded one cycle after `in_valid`=1 and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request this cycle |
| legacy | input | 1 | 1 selects the legacy 128-bit mode |
| elem64 | input | 1 | Lane size: 0 = 32-bit, 1 = 64-bit |
| vlen | input | 2 | Active length: 0 = 128, 1 = 256, 2 or 3 = 512 bits |
| src1 | input | DW | First source vector |
| src2 | input | DW | Second source vector |
| src2_mem | input | 1 | Second source comes from memory |
| bcast | input | 1 | Broadcast request for the lowest element of `src2` |
| old_dst | input | DW | Previous destination value |
| mask_en | input | 1 | Enables the per-lane write mask |
| mask | input | DW/32 | Per-lane write mask, bit j for lane j |
| zero_mode | input | 1 | Unwritten lanes: 0 = keep old value, 1 = write zero |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| dst | output | DW | Registered destination vector |

## Verification
The bench builds the unit with the default DW=512, which gives a 16-bit mask. This width makes every combination of the two lane sizes and the three active lengths reachable, including the 16-lane and 8-lane full-width cases. At 128 bits it also leaves twelve mask bits above the active lanes, so the test that upper mask bits are ignored is meaningful. Random operands are seeded with deliberate ties and all-ones values, so that the tie rule and the unsigned comparison are both exercised.

// File: rtl/masked_umin.sv
module masked_umin #(
  parameter int DW = 512
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            legacy,
  input  logic            elem64,
  input  logic [1:0]      vlen,
  input  logic [DW-1:0]   src1,
  input  logic [DW-1:0]   src2,
  input  logic            src2_mem,
  input  logic            bcast,
  input  logic [DW-1:0]   old_dst,
  input  logic            mask_en,
  input  logic [DW/32-1:0] mask,
  input  logic            zero_mode,
  output logic            out_valid,
  output logic [DW-1:0]   dst
);
  localparam int ND = DW / 32;
  localparam int NQ = DW / 64;
  localparam int AW = $clog2(ND) + 1;

  wire use_bc  = !legacy && bcast && src2_mem;
  wire use_msk = !legacy && mask_en;
  wire use_q   = !legacy && elem64;
  wire [DW-1:0] opa = legacy ? old_dst : src1;

  logic [AW-1:0] act;
  always_comb begin
    act = AW'(ND);
    if (legacy || vlen == 2'd0) act = AW'(4);
    else if (vlen == 2'd1)      act = AW'(8);
  end

  logic [DW-1:0] res_d, res_q, nxt;

  for (genvar g = 0; g < ND; g++) begin : g_dw
    wire [31:0] a  = opa[32*g +: 32];
    wire [31:0] b  = use_bc ? src2[31:0] : src2[32*g +: 32];
    wire [31:0] mn = (a < b) ? a : b;
    assign res_d[32*g +: 32] = (!use_msk || mask[g]) ? mn
                             : (zero_mode ? 32'd0 : old_dst[32*g +: 32]);
  end

  for (genvar g = 0; g < NQ; g++) begin : g_qw
    wire [63:0] a  = opa[64*g +: 64];
    wire [63:0] b  = use_bc ? src2[63:0] : src2[64*g +: 64];
    wire [63:0] mn = (a < b) ? a : b;
    assign res_q[64*g +: 64] = (!use_msk || mask[g]) ? mn
                             : (zero_mode ? 64'd0 : old_dst[64*g +: 64]);
  end

  for (genvar s = 0; s < ND; s++) begin : g_sel
    assign nxt[32*s +: 32] = (AW'(s) < act) ? (use_q ? res_q[32*s +: 32] : res_d[32*s +: 32])
                           : (legacy ? old_dst[32*s +: 32] : 32'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) dst <= nxt;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(dst))); // R10
  AST_UPPER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legacy && vlen == 2'd0) |=> (dst[DW-1:128] == '0)); // R3
  AST_LEGACY_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legacy) |=> (dst[DW-1:128] == $past(old_dst[DW-1:128]))); // R9
  AST_ZERO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legacy && mask_en && zero_mode && !mask[0]) |=> (dst[31:0] == 32'd0)); // R5
  AST_MIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legacy && !mask_en && !elem64 && !src2_mem)
      |=> (dst[31:0] <= $past(src1[31:0]) && dst[31:0] <= $past(src2[31:0]))); // R1
endmodule

// File: tb/sim_masked_umin.sv
`timescale 1ns/1ps
module sim_masked_umin;
  localparam int DW = 512;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic legacy = 1'b0, elem64 = 1'b0, src2_mem = 1'b0, bcast = 1'b0;
  logic mask_en = 1'b0, zero_mode = 1'b0;
  logic [1:0] vlen = 2'd0;
  logic [DW-1:0] src1 = '0, src2 = '0, old_dst = '0;
  logic [DW/32-1:0] mask = '0;
  logic out_valid;
  logic [DW-1:0] dst;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  masked_umin #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .legacy(legacy), .elem64(elem64),
    .vlen(vlen), .src1(src1), .src2(src2), .src2_mem(src2_mem), .bcast(bcast),
    .old_dst(old_dst), .mask_en(mask_en), .mask(mask), .zero_mode(zero_mode),
    .out_valid(out_valid), .dst(dst));

  function automatic logic [DW-1:0] rnd();
    logic [DW-1:0] v;
    for (int i = 0; i < DW/32; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [DW-1:0] model();
    logic [DW-1:0] a, r;
    int esz, bits, lanes;
    logic m_on, b_on;
    logic [63:0] x, y, mn, em;
    a = legacy ? old_dst : src1;
    r = legacy ? old_dst : '0;
    esz = (!legacy && elem64) ? 64 : 32;
    bits = legacy ? 128 : (vlen == 0 ? 128 : (vlen == 1 ? 256 : 512));
    lanes = bits / esz;
    m_on = !legacy && mask_en;
    b_on = !legacy && bcast && src2_mem;
    em = (esz == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    for (int j = 0; j < lanes; j++) begin
      x = 64'(a >> (j*esz)) & em;
      y = b_on ? (64'(src2) & em) : (64'(src2 >> (j*esz)) & em);
      mn = (x < y) ? x : y;
      if (m_on && !mask[j]) mn = zero_mode ? 64'd0 : (64'(old_dst >> (j*esz)) & em);
      for (int k = 0; k < esz; k++) r[j*esz + k] = mn[k];
    end
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fire(string tag);
    logic [DW-1:0] exp;
    exp = model();
    in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, {tag, " out_valid (R10)"}, DW'(out_valid), DW'(1));
    chk(dst === exp, tag, dst, exp);
  endtask

  task automatic new_ops();
    src1 = rnd(); src2 = rnd(); old_dst = rnd();
    for (int i = 0; i < DW/32; i += 3) src2[32*i +: 32] = src1[32*i +: 32];
    src1[63:32] = 32'hFFFF_FFFF;
    src2[95:64] = 32'hFFFF_FFFF;
  endtask

  task automatic set_ext(bit e64, logic [1:0] vl);
    legacy = 0; elem64 = e64; vlen = vl; mask_en = 0; zero_mode = 0;
    bcast = 0; src2_mem = 0; mask = '0;
  endtask

  task automatic t_reset();
    chk(dst === '0 && out_valid === 1'b0, "R10 reset state", dst, '0);
  endtask

  task automatic t_basic();
    set_ext(0, 2'd2);
    for (int n = 0; n < 3; n++) begin new_ops(); fire("R1 dword min 512"); end
    new_ops(); src2 = src1; fire("R1 full tie");
  endtask

  task automatic t_qword();
    for (int v = 0; v < 4; v++) begin
      set_ext(1, 2'(v)); new_ops(); fire("R2 qword lanes");
    end
  endtask

  task automatic t_vlen();
    for (int v = 0; v < 4; v++) begin
      set_ext(0, 2'(v)); new_ops(); fire("R3 dword length");
    end
  endtask

  task automatic t_merge();
    set_ext(0, 2'd2); mask_en = 1; mask = 16'hA5C3; new_ops(); fire("R4 merge dword");
    set_ext(1, 2'd1); mask_en = 1; mask = 16'h0006; new_ops(); fire("R4 merge qword");
    set_ext(0, 2'd2); mask_en = 0; mask = 16'h0000; new_ops(); fire("R4 mask off ignores mask");
  endtask

  task automatic t_zero();
    set_ext(0, 2'd1); mask_en = 1; zero_mode = 1; mask = 16'h005A; new_ops(); fire("R5 zeroing dword");
    set_ext(1, 2'd2); mask_en = 1; zero_mode = 1; mask = 16'h0081; new_ops(); fire("R5 zeroing qword");
  endtask

  task automatic t_mask_high();
    logic [DW-1:0] exp;
    set_ext(0, 2'd0); mask_en = 1; mask = 16'hFFF5; new_ops(); fire("R6 high mask bits dword");
    exp = dst;
    mask = 16'h0005; fire("R6 same result low bits");
    chk(dst === exp, "R6 high bits no effect", dst, exp);
    set_ext(1, 2'd0); mask_en = 1; zero_mode = 1; mask = 16'hFFFC; new_ops(); fire("R6 high mask bits qword");
  endtask

  task automatic t_bcast();
    set_ext(0, 2'd2); bcast = 1; src2_mem = 1; new_ops(); fire("R7 broadcast dword");
    set_ext(1, 2'd2); bcast = 1; src2_mem = 1; new_ops(); fire("R7 broadcast qword");
    set_ext(0, 2'd1); bcast = 1; src2_mem = 1; mask_en = 1; mask = 16'h00F0; new_ops(); fire("R7 broadcast masked");
  endtask

  task automatic t_bcast_nomem();
    set_ext(0, 2'd2); bcast = 1; src2_mem = 0; new_ops(); fire("R8 broadcast without memory");
    set_ext(1, 2'd2); bcast = 1; src2_mem = 0; new_ops(); fire("R8 broadcast without memory qword");
  endtask

  task automatic t_legacy();
    legacy = 1; elem64 = 1; vlen = 2'd2; mask_en = 1; mask = 16'h0000;
    zero_mode = 1; bcast = 1; src2_mem = 1;
    new_ops(); fire("R9 legacy ignores controls");
    new_ops(); src2[127:0] = old_dst[127:0]; fire("R9 legacy tie");
    legacy = 0;
  endtask

  task automatic t_hold();
    logic [DW-1:0] keep;
    set_ext(0, 2'd2); new_ops(); fire("R10 load");
    keep = dst;
    new_ops();
    @(posedge clk); @(negedge clk);
    chk(out_valid === 1'b0, "R10 valid drops", DW'(out_valid), '0);
    chk(dst === keep, "R10 dst holds", dst, keep);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_basic();
    t_qword();
    t_vlen();
    t_merge();
    t_zero();
    t_mask_high();
    t_bcast();
    t_bcast_nomem();
    t_legacy();
    t_hold();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule